// File: doc/BRIEF.md
# Trapping Unsigned/Signed Divider

This block is the divide unit of a 16-bit x86-class execution core. It serves the two divide sub-operations of the unary group opcodes: sub-operation 6 is the unsigned divide and sub-operation 7 is the signed divide. A byte-width operation divides the 16-bit accumulator by an 8-bit divisor and yields an 8-bit quotient and remainder. A word-width operation divides the 32-bit pair formed by the high and low accumulator words by a 16-bit divisor and yields a 16-bit quotient and remainder. The core fetches the operand from a register or from memory and passes it in. The core also runs the interrupt sequence that the divide-error request starts. Both of those tasks are outside this block.

Internally the unit works on magnitudes. It runs restoring division at one quotient bit per clock over the whole dividend width, so the full untruncated quotient is available for the range check. A final pass applies the signs: the quotient is truncated toward zero and the remainder takes the sign of the dividend. The pass then checks the result against the range of the destination width. A zero divisor does not start the datapath and raises the type-0 request at once. When the quotient is out of range, the truncated quotient and remainder are still written, and the error request pulses in the same cycle as the done strobe. Each finished operation also reports a fixed cycle cost. The cost depends on width, signedness and operand source.

The controller has three states. IDLE waits for an accepted start. ITER runs one restoring step per clock. FIX applies the signs, checks the range and registers the results. Its transitions are:
- accept-nonzero: IDLE to ITER.
- accept-zero: IDLE to IDLE, with the error pulse.
- last-step: ITER to FIX.
- retire: FIX to IDLE.
- hold: every other case keeps the current state.

Top module: `divtrap_unit`

## Requirements
- R1: A start is accepted only in IDLE and only when `op_sel` is 6 (unsigned) or 7 (signed). A start with any other `op_sel` value produces no done or error pulse and leaves `quotient` and `remainder` unchanged.
- R2: In byte mode (`word_mode`=0) the dividend is `acc_lo` and the divisor is `divisor[BYTE_W-1:0]`. `acc_hi` and the upper divisor bits are ignored. The quotient appears in `quotient[BYTE_W-1:0]` and the remainder in `remainder[BYTE_W-1:0]`, with the upper halves of both outputs zero.
- R3: An unsigned byte quotient above 2^BYTE_W-1 raises `div_err` in the same cycle as `done`. The low BYTE_W bits of the quotient and the remainder are still written.
- R4: A signed byte divide truncates toward zero, and its remainder has the sign of the dividend. A quotient outside -2^(BYTE_W-1)..2^(BYTE_W-1)-1 raises `div_err` together with `done`, and the truncated results are still written.
- R5: In word mode the dividend is {`acc_hi`,`acc_lo`} and the divisor is the full `divisor`. The quotient and remainder fill the full output width. An unsigned quotient of 2^(2*BYTE_W) or more raises `div_err` together with `done`.
- R6: A signed word quotient outside -2^(2*BYTE_W-1)..2^(2*BYTE_W-1)-1 raises `div_err` together with `done`. The truncated results are still written.
- R7: A zero divisor (within the width in use) raises `div_err` alone, with no `done` pulse, on the edge after the accepting edge. `quotient` and `remainder` keep their previous values.
- R8: With the default cost parameters, `cost` reports the following values when `done` or `div_err` pulses:
  - unsigned byte: 14 for a register operand, 17 when `mem_src` is 1;
  - signed byte: 17 for a register operand, 20 when `mem_src` is 1;
  - unsigned word: 22 for a register operand, 25 when `mem_src` is 1;
  - signed word: 25 for a register operand, 28 when `mem_src` is 1.
- R9: For a nonzero divisor, `done` is set by the (2*BYTE_W+1)-th rising edge after the accepting edge in byte mode, and by the (4*BYTE_W+1)-th in word mode.
- R10: A start raised while an operation is in progress is ignored. The running operation completes with its own operands and produces exactly one result.
- R11: `done` and `div_err` are single-cycle pulses, and all outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a divide |
| op_sel | input | 3 | Group sub-operation: 6 unsigned, 7 signed |
| word_mode | input | 1 | 0 byte width, 1 word width |
| mem_src | input | 1 | Divisor came from memory (affects cost only) |
| acc_lo | input | 2*BYTE_W | Low accumulator word (byte-mode dividend) |
| acc_hi | input | 2*BYTE_W | High accumulator word (word mode only) |
| divisor | input | 2*BYTE_W | Divisor; low BYTE_W bits in byte mode |
| done | output | 1 | Result written pulse |
| div_err | output | 1 | Type-0 divide-error request pulse |
| quotient | output | 2*BYTE_W | Quotient (low accumulator destination) |
| remainder | output | 2*BYTE_W | Remainder (byte: high half of accumulator; word: high word) |
| cost | output | COST_W | Cycle cost of the last finished operation |

## Verification
The bench builds the unit with BYTE_W=4 and default costs. Byte mode then becomes an 8-bit by 4-bit divide, small enough to sweep exhaustively. The sweep covers every dividend against every divisor, both signed and unsigned, so every overflow boundary, every negative remainder and every zero divisor in that width is hit. Word mode becomes 16 by 8 bits and is covered by a stepped sample plus the extreme signed cases, such as the most negative dividend divided by minus one and results that land exactly on the range limits. The narrow width keeps the run short, so the bench can also count latency exactly for every operation.

// File: rtl/divt_pkg.sv
package divt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    localparam logic [2:0] OP_UDIV = 3'd6;
    localparam logic [2:0] OP_SDIV = 3'd7;

endpackage

// File: rtl/divt_operand_prep.sv
module divt_operand_prep #(
    parameter int BYTE_W = 8
) (
    input  logic                  word_i,
    input  logic                  signed_i,
    input  logic [2*BYTE_W-1:0]   acc_lo_i,
    input  logic [2*BYTE_W-1:0]   acc_hi_i,
    input  logic [2*BYTE_W-1:0]   divisor_i,
    output logic [4*BYTE_W-1:0]   load_o,
    output logic [2*BYTE_W-1:0]   dsr_mag_o,
    output logic                  dvd_neg_o,
    output logic                  quo_neg_o,
    output logic                  dsr_zero_o
);
    localparam int W  = 2 * BYTE_W;
    localparam int D2 = 2 * W;

    logic [D2-1:0]     pair;
    logic [D2-1:0]     pair_mag;
    logic [W-1:0]      lo_mag;
    logic [BYTE_W-1:0] dsr_b;
    logic [BYTE_W-1:0] dsr_b_mag;
    logic [W-1:0]      dsr_w_mag;
    logic              dvd_sign;
    logic              dsr_sign;
    logic              dsr_neg;

    always_comb begin
        pair  = {acc_hi_i, acc_lo_i};
        dsr_b = divisor_i[BYTE_W-1:0];
        if (word_i) begin
            dvd_sign = acc_hi_i[W-1];
            dsr_sign = divisor_i[W-1];
        end else begin
            dvd_sign = acc_lo_i[W-1];
            dsr_sign = dsr_b[BYTE_W-1];
        end
        dvd_neg_o = signed_i & dvd_sign;
        dsr_neg   = signed_i & dsr_sign;
        quo_neg_o = dvd_neg_o ^ dsr_neg;

        pair_mag  = dvd_neg_o ? ({D2{1'b0}} - pair) : pair;
        lo_mag    = dvd_neg_o ? ({W{1'b0}} - acc_lo_i) : acc_lo_i;
        dsr_b_mag = dsr_neg ? ({BYTE_W{1'b0}} - dsr_b) : dsr_b;
        dsr_w_mag = dsr_neg ? ({W{1'b0}} - divisor_i) : divisor_i;

        if (word_i) begin
            load_o     = pair_mag;
            dsr_mag_o  = dsr_w_mag;
            dsr_zero_o = (divisor_i == '0);
        end else begin
            load_o     = {lo_mag, {W{1'b0}}};
            dsr_mag_o  = {{BYTE_W{1'b0}}, dsr_b_mag};
            dsr_zero_o = (dsr_b == '0);
        end
    end

endmodule

// File: rtl/divt_restoring_core.sv
module divt_restoring_core #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic                  step_i,
    input  logic [4*BYTE_W-1:0]   dvd_i,
    input  logic [2*BYTE_W-1:0]   dsr_i,
    output logic [4*BYTE_W-1:0]   quo_o,
    output logic [2*BYTE_W-1:0]   rem_o
);
    localparam int W  = 2 * BYTE_W;
    localparam int D2 = 2 * W;

    logic [W-1:0]  rem_q;
    logic [W-1:0]  dsr_q;
    logic [D2-1:0] quo_q;
    logic [W:0]    trial;
    logic [W:0]    diff;
    logic          fits;

    always_comb begin
        trial = {rem_q, quo_q[D2-1]};
        diff  = trial - {1'b0, dsr_q};
        fits  = (trial >= {1'b0, dsr_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            dsr_q <= '0;
            quo_q <= '0;
        end else if (load_i) begin
            rem_q <= '0;
            dsr_q <= dsr_i;
            quo_q <= dvd_i;
        end else if (step_i) begin
            rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
            quo_q <= {quo_q[D2-2:0], fits};
        end
    end

    assign quo_o = quo_q;
    assign rem_o = rem_q;

    // Partial remainder stays below the divisor during every step (R2, R5).
    assert_partial_rem_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (rem_q < dsr_q));

endmodule

// File: rtl/divt_result_fix.sv
module divt_result_fix #(
    parameter int BYTE_W = 8
) (
    input  logic                  word_i,
    input  logic                  signed_i,
    input  logic                  dvd_neg_i,
    input  logic                  quo_neg_i,
    input  logic [4*BYTE_W-1:0]   quo_mag_i,
    input  logic [2*BYTE_W-1:0]   rem_mag_i,
    output logic [2*BYTE_W-1:0]   quotient_o,
    output logic [2*BYTE_W-1:0]   remainder_o,
    output logic                  ovf_o
);
    localparam int W  = 2 * BYTE_W;
    localparam int D2 = 2 * W;
    localparam logic [D2-1:0] LIM_B = D2'(1) << (BYTE_W - 1);
    localparam logic [D2-1:0] LIM_W = D2'(1) << (W - 1);

    logic [D2-1:0] q_signed;
    logic [W-1:0]  r_signed;
    logic [D2-1:0] lim;

    always_comb begin
        q_signed = quo_neg_i ? ({D2{1'b0}} - quo_mag_i) : quo_mag_i;
        r_signed = dvd_neg_i ? ({W{1'b0}} - rem_mag_i) : rem_mag_i;
        lim      = word_i ? LIM_W : LIM_B;

        if (signed_i)
            ovf_o = quo_neg_i ? (quo_mag_i > lim) : (quo_mag_i >= lim);
        else if (word_i)
            ovf_o = |quo_mag_i[D2-1:W];
        else
            ovf_o = |quo_mag_i[D2-1:BYTE_W];

        if (word_i) begin
            quotient_o  = q_signed[W-1:0];
            remainder_o = r_signed;
        end else begin
            quotient_o  = {{BYTE_W{1'b0}}, q_signed[BYTE_W-1:0]};
            remainder_o = {{BYTE_W{1'b0}}, r_signed[BYTE_W-1:0]};
        end
    end

endmodule

// File: rtl/divtrap_unit.sv
module divtrap_unit
    import divt_pkg::*;
#(
    parameter int BYTE_W         = 8,
    parameter int COST_W         = 8,
    parameter int COST_DIV_B     = 14,
    parameter int COST_IDIV_B    = 17,
    parameter int COST_DIV_W     = 22,
    parameter int COST_IDIV_W    = 25,
    parameter int COST_MEM_EXTRA = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [2:0]            op_sel,
    input  logic                  word_mode,
    input  logic                  mem_src,
    input  logic [2*BYTE_W-1:0]   acc_lo,
    input  logic [2*BYTE_W-1:0]   acc_hi,
    input  logic [2*BYTE_W-1:0]   divisor,
    output logic                  done,
    output logic                  div_err,
    output logic [2*BYTE_W-1:0]   quotient,
    output logic [2*BYTE_W-1:0]   remainder,
    output logic [COST_W-1:0]     cost
);
    localparam int W     = 2 * BYTE_W;
    localparam int D2    = 2 * W;
    localparam int CNT_W = $clog2(D2);
    localparam logic [CNT_W-1:0] STEPS_B = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] STEPS_W = CNT_W'(D2 - 1);

    function automatic logic [COST_W-1:0] cost_of(input logic w, input logic s, input logic m);
        int c;
        c = w ? (s ? COST_IDIV_W : COST_DIV_W) : (s ? COST_IDIV_B : COST_DIV_B);
        if (m) c = c + COST_MEM_EXTRA;
        return COST_W'(c);
    endfunction

    div_state_e st_q, st_d;

    logic [CNT_W-1:0] cnt_q;
    logic             wide_q, signed_q, mem_q, dvd_neg_q, quo_neg_q;
    logic             op_ok, op_signed, accept;

    logic [D2-1:0]    load_val;
    logic [W-1:0]     dsr_mag;
    logic             dvd_neg, quo_neg, dsr_zero;
    logic [D2-1:0]    core_quo;
    logic [W-1:0]     core_rem;
    logic [W-1:0]     fix_quo, fix_rem;
    logic             fix_ovf;

    logic             done_q, err_q;
    logic [W-1:0]     quo_out_q, rem_out_q;
    logic [COST_W-1:0] cost_q;

    assign op_ok     = (op_sel == OP_UDIV) || (op_sel == OP_SDIV);
    assign op_signed = (op_sel == OP_SDIV);
    assign accept    = start && op_ok && (st_q == ST_IDLE);

    divt_operand_prep #(.BYTE_W(BYTE_W)) prep_i (
        .word_i     (word_mode),
        .signed_i   (op_signed),
        .acc_lo_i   (acc_lo),
        .acc_hi_i   (acc_hi),
        .divisor_i  (divisor),
        .load_o     (load_val),
        .dsr_mag_o  (dsr_mag),
        .dvd_neg_o  (dvd_neg),
        .quo_neg_o  (quo_neg),
        .dsr_zero_o (dsr_zero)
    );

    divt_restoring_core #(.BYTE_W(BYTE_W)) core_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept && !dsr_zero),
        .step_i (st_q == ST_ITER),
        .dvd_i  (load_val),
        .dsr_i  (dsr_mag),
        .quo_o  (core_quo),
        .rem_o  (core_rem)
    );

    divt_result_fix #(.BYTE_W(BYTE_W)) fix_i (
        .word_i      (wide_q),
        .signed_i    (signed_q),
        .dvd_neg_i   (dvd_neg_q),
        .quo_neg_i   (quo_neg_q),
        .quo_mag_i   (core_quo),
        .rem_mag_i   (core_rem),
        .quotient_o  (fix_quo),
        .remainder_o (fix_rem),
        .ovf_o       (fix_ovf)
    );

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept && !dsr_zero) st_d = ST_ITER;
            ST_ITER: if (cnt_q == '0)         st_d = ST_FIX;
            ST_FIX:                           st_d = ST_IDLE;
            default:                          st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Operation context: step counter and latched attributes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            wide_q    <= 1'b0;
            signed_q  <= 1'b0;
            mem_q     <= 1'b0;
            dvd_neg_q <= 1'b0;
            quo_neg_q <= 1'b0;
        end else if (accept && !dsr_zero) begin
            cnt_q     <= word_mode ? STEPS_W : STEPS_B;
            wide_q    <= word_mode;
            signed_q  <= op_signed;
            mem_q     <= mem_src;
            dvd_neg_q <= dvd_neg;
            quo_neg_q <= quo_neg;
        end else if (st_q == ST_ITER) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            quo_out_q <= '0;
            rem_out_q <= '0;
            cost_q    <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept && dsr_zero) begin
                        err_q  <= 1'b1;
                        cost_q <= cost_of(word_mode, op_signed, mem_src);
                    end
                end
                ST_ITER: begin
                end
                ST_FIX: begin
                    done_q    <= 1'b1;
                    err_q     <= fix_ovf;
                    quo_out_q <= fix_quo;
                    rem_out_q <= fix_rem;
                    cost_q    <= cost_of(wide_q, signed_q, mem_q);
                end
                default: begin
                end
            endcase
        end
    end

    assign done      = done_q;
    assign div_err   = err_q;
    assign quotient  = quo_out_q;
    assign remainder = rem_out_q;
    assign cost      = cost_q;

    // Zero divisor traps on the next edge without a result (R7).
    assert_zero_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dsr_zero) |=> (div_err && !done));

    // Done is a single-cycle pulse (R11).
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A start during a running operation leaves its context untouched (R10).
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && start) |=> ($stable(wide_q) && $stable(signed_q) && $stable(mem_q)));

    // Unsigned byte result without error has a quotient that fits the byte (R3).
    assert_byte_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FIX && !wide_q && !signed_q && !fix_ovf) |-> (core_quo[D2-1:BYTE_W] == '0));

endmodule

// File: tb/divtrap_unit_tb_top.sv
module divtrap_unit_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  B          = 4;
    localparam int  W          = 2 * B;
    localparam int  WATCHDOG   = 190000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   op_sel = 3'd0;
    logic         word_mode = 1'b0;
    logic         mem_src = 1'b0;
    logic [W-1:0] acc_lo = '0, acc_hi = '0, divisor = '0;
    logic         done, div_err;
    logic [W-1:0] quotient, remainder;
    logic [7:0]   cost;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] last_q = '0, last_r = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    divtrap_unit #(.BYTE_W(B)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .word_mode(word_mode), .mem_src(mem_src), .acc_lo(acc_lo),
        .acc_hi(acc_hi), .divisor(divisor), .done(done), .div_err(div_err),
        .quotient(quotient), .remainder(remainder), .cost(cost)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input bit wd, input bit sg, input bit mem,
                          input logic [W-1:0] hi, input logic [W-1:0] lo,
                          input logic [W-1:0] dsr, input bit interfere);
        longint dvd, dsv, q, r, lo_lim, hi_lim, mask;
        bit zero, ovf;
        int n, exp_n, exp_cost;
        logic [W-1:0] eq, er;
        string tag;
        if (wd) begin
            dvd    = sg ? longint'($signed({hi, lo})) : longint'({hi, lo});
            dsv    = sg ? longint'($signed(dsr)) : longint'(dsr);
            hi_lim = sg ? (longint'(1) <<< (W-1)) - 1 : (longint'(1) <<< W) - 1;
            lo_lim = sg ? -(longint'(1) <<< (W-1)) : 0;
            mask   = (longint'(1) <<< W) - 1;
        end else begin
            dvd    = sg ? longint'($signed(lo)) : longint'(lo);
            dsv    = sg ? longint'($signed(dsr[B-1:0])) : longint'(dsr[B-1:0]);
            hi_lim = sg ? (longint'(1) <<< (B-1)) - 1 : (longint'(1) <<< B) - 1;
            lo_lim = sg ? -(longint'(1) <<< (B-1)) : 0;
            mask   = (longint'(1) <<< B) - 1;
        end
        zero = (dsv == 0);
        q = 0; r = 0; ovf = 1'b0;
        if (!zero) begin
            q   = dvd / dsv;
            r   = dvd % dsv;
            ovf = (q < lo_lim) || (q > hi_lim);
        end
        eq = W'(q & mask);
        er = W'(r & mask);
        if (interfere)  tag = "R10";
        else if (zero)  tag = "R7";
        else if (wd)    tag = sg ? "R6" : "R5";
        else if (sg)    tag = "R4";
        else            tag = ovf ? "R3" : "R2";
        exp_cost = (wd ? (sg ? 25 : 22) : (sg ? 17 : 14)) + (mem ? 3 : 0);
        exp_n    = zero ? 1 : (wd ? 4*B+2 : 2*B+2);

        @(negedge clk);
        start = 1'b1; op_sel = sg ? 3'd7 : 3'd6; word_mode = wd; mem_src = mem;
        acc_hi = hi; acc_lo = lo; divisor = dsr;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!(done || div_err) && n < 64) begin
            if (interfere && n == 3) begin
                start = 1'b1; op_sel = 3'd6; word_mode = ~wd; acc_lo = ~lo; divisor = 8'h01;
            end
            if (interfere && n == 6) start = 1'b0;
            @(negedge clk);
            n++;
        end
        chk(n == exp_n, "R9", "latency", n, exp_n);
        chk(done == !zero, tag, "done", done, !zero);
        chk(div_err == (zero || ovf), tag, "div_err", div_err, zero || ovf);
        if (zero) begin
            chk(quotient == last_q, tag, "quotient kept", quotient, last_q);
            chk(remainder == last_r, tag, "remainder kept", remainder, last_r);
        end else begin
            chk(quotient == eq, tag, "quotient", quotient, eq);
            chk(remainder == er, tag, "remainder", remainder, er);
            last_q = eq;
            last_r = er;
        end
        chk(cost == exp_cost, "R8", "cost", cost, exp_cost);
    endtask

    task automatic check_ignored(input logic [2:0] op);
        int pulses;
        pulses = 0;
        @(negedge clk);
        start = 1'b1; op_sel = op; word_mode = 1'b0; acc_lo = 8'h64; divisor = 8'h03;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (done || div_err) pulses++;
            @(negedge clk);
        end
        chk(pulses == 0, "R1", "pulses for invalid op", pulses, 0);
        chk(quotient == last_q, "R1", "quotient after invalid op", quotient, last_q);
    endtask

    task automatic quiet_window(input int len);
        int pulses;
        pulses = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (done || div_err) pulses++;
        end
        chk(pulses == 0, "R11", "extra pulses", pulses, 0);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog actual=expired expected=finished");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(done == 1'b0, "R11", "reset done", done, 0);
        chk(div_err == 1'b0, "R11", "reset div_err", div_err, 0);
        chk(quotient == '0, "R11", "reset quotient", quotient, 0);
        chk(remainder == '0, "R11", "reset remainder", remainder, 0);
        chk(cost == '0, "R11", "reset cost", cost, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed word corners (R5, R6)
        run_op(1, 1, 0, 8'h80, 8'h00, 8'hFF, 0);
        run_op(1, 1, 1, 8'hFF, 8'h80, 8'h01, 0);
        run_op(1, 1, 0, 8'h00, 8'h80, 8'h01, 0);
        run_op(1, 0, 0, 8'hFF, 8'hFF, 8'hFF, 0);
        run_op(1, 0, 1, 8'hFE, 8'hFF, 8'hFF, 0);
        run_op(1, 1, 0, 8'hFF, 8'hF9, 8'h02, 0);
        run_op(1, 0, 0, 8'h12, 8'h34, 8'h00, 0);
        quiet_window(3);

        // R1: invalid sub-operations
        check_ignored(3'd5);
        check_ignored(3'd0);

        // R10: start while busy, then nothing further (R11)
        run_op(1, 0, 0, 8'h12, 8'h34, 8'h56, 1);
        quiet_window(25);
        run_op(0, 0, 1, 8'h00, 8'h00, 8'h00, 0);
        quiet_window(2);

        // Exhaustive byte sweep (R2, R3, R4, R7)
        for (int sg = 0; sg < 2; sg++)
            for (int lo = 0; lo < 256; lo++)
                for (int d = 0; d < 16; d++)
                    run_op(0, sg[0], lo[0] ^ d[0], W'(lo ^ 8'h5A),
                           W'(lo), {lo[3:0], d[3:0]}, 0);

        // Sampled word sweep (R5, R6, R7)
        for (int sg = 0; sg < 2; sg++)
            for (int i = 0; i < 1200; i++) begin
                logic [15:0] dv;
                logic [7:0]  ds;
                dv = 16'(i * 40503 + 17 + sg * 911);
                ds = (i % 4 == 0) ? 8'(i % 5) : 8'(i * 37 + 1);
                run_op(1, sg[0], i[1], dv[15:8], dv[7:0], ds, 0);
            end

        report();
        $finish;
    end

endmodule